// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block combines a byte-programmable watchdog timer with a two-bit record of why the system last came out of reset. Software writes a timeout byte through a small register-write port. It then arms the timer with a separate trigger strobe. While the timer is armed, the kick strobe restarts the count. Each count of the timeout lasts `PRESCALE` clock cycles. When the count runs out, the block raises a reset request for one cycle. It also records the watchdog as the reset cause. An input from the real-time-clock domain records a second cause: the clock contents were restored to defaults.

Software reads the timeout, the cause flags and a small power-control register through a combinational read port. It clears cause flags by writing ones to them. The power-control register keeps only its low bits. One of those bits does not hold a value: writing a one to it produces a one-cycle service pulse that acts as a kick. The cause flags live in the power-on domain. The watchdog's own reset request does not clear them, so software can see after the restart that both flags are set. The timeout is copied into the counter only when the trigger arrives. A rewrite of the timeout byte after the trigger changes nothing until the next trigger.

Top module: `wdt_cause_top`

## Requirements
- R1: After `por_n` is released, the timeout, cause and power-control registers read 0 and `sys_rst_req` is low.
- R2: Select 0 is the timeout byte. A write stores all 8 bits, and a read returns them.
- R3: On `trigger`, the block copies the timeout byte into the counter. If that byte is 0, the watchdog is disarmed and never expires, even if it was running.
- R4: A timeout write made after a trigger leaves the running count unchanged. The new value takes effect only at the next trigger.
- R5: The first clock edge after a trigger is edge 0. With a copied value T, `sys_rst_req` is high for exactly one cycle, starting at edge T*PRESCALE. The watchdog is then disarmed.
- R6: Expiry sets cause bit 1 (watchdog) and cause bit 0 together, so the cause reads 3. The flags stay set until acknowledged. Only `por_n` clears them.
- R7: A high `rtc_restored` sets cause bit 0 (clock restored to defaults) at the next edge.
- R8: Select 1 is the cause register. A write with a 1 in bit 0 or bit 1 clears that bit, and a 0 leaves it. Bits 7:2 of the write data are ignored. If a set and a clear of the same bit arrive in the same cycle, the set wins.
- R9: While the watchdog is armed, `kick` reloads the counter from the value copied at the trigger, not from the timeout register. The next expiry is then T*PRESCALE edges after the kick edge. While disarmed, `kick` has no effect.
- R10: Select 2 is power control. Bits 2:0 are stored. Bits 7:4 are discarded, and bit 3 always reads 0. Writing 1 to bit 3 yields a one-cycle service pulse that acts as a kick one cycle later.
- R11: Select 3 is unmapped. Reads return 0xFF, and writes change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 8 | Read data, combinational |
| trigger | input | 1 | Arm the watchdog using the current timeout byte |
| kick | input | 1 | Restart the running count |
| rtc_restored | input | 1 | The clock domain reports that its contents were restored to defaults |
| sys_rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
On every cycle, the assertions check the following:
- a single-cycle reset request;
- a cause of 3 whenever the request is high;
- disarming by a zero trigger;
- reload of the copied value on a kick;
- the copied value holding steady between triggers;
- the clock-restored flag being set;
- zero upper bits in power-control reads.

Only the bench scenarios can show the rest. These are the exact expiry distance in cycles and that a late timeout write leaves that distance unchanged. They also show that the service pulse lengthens the deadline by one cycle, and that partial and collided acknowledges leave the right flag set.

// File: rtl/wdt_cause_pkg.sv
package wdt_cause_pkg;

  typedef enum logic [1:0] {
    SEL_TMO   = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_PWR   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int CAUSE_W   = 2;
  localparam int PWR_KEEP  = 3;   // stored power-control bits
  localparam int SVC_BIT   = 3;   // self-clearing service bit

  // Cause update: acknowledge clears, set events win over clears.
  function automatic logic [CAUSE_W-1:0] cause_next(
      input logic [CAUSE_W-1:0] cur,
      input logic [CAUSE_W-1:0] set,
      input logic [CAUSE_W-1:0] ack);
    return (cur & ~ack) | set;
  endfunction

  // Cycles from the arming edge to the expiry edge.
  function automatic int unsigned expire_cycles(input int unsigned t, input int unsigned pre);
    return t * pre;
  endfunction

endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_cause_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] timeout,
  output logic [PWR_KEEP-1:0] pwr_bits,
  output logic              svc_pulse
);

  logic wr_tmo, wr_pwr;
  assign wr_tmo = wr_en && (reg_sel_e'(wr_sel) == SEL_TMO);
  assign wr_pwr = wr_en && (reg_sel_e'(wr_sel) == SEL_PWR);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      timeout   <= '0;
      pwr_bits  <= '0;
      svc_pulse <= 1'b0;
    end else begin
      if (wr_tmo) timeout <= wr_data;
      if (wr_pwr) pwr_bits <= wr_data[PWR_KEEP-1:0];
      svc_pulse <= wr_pwr && wr_data[SVC_BIT];
    end
  end

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int TMO_W    = 8,
  parameter int PRESCALE = 1024
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             trigger,
  input  logic             kick_eff,
  input  logic [TMO_W-1:0] timeout,
  output logic             armed,
  output logic             tick,
  output logic [TMO_W-1:0] count,
  output logic [TMO_W-1:0] latched,
  output logic             expire
);

  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre;

  assign tick   = armed && (pre == PRE_LAST);
  assign expire = tick && (count == TMO_W'(1)) && !trigger && !kick_eff;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed   <= 1'b0;
      pre     <= '0;
      count   <= '0;
      latched <= '0;
    end else if (trigger) begin
      latched <= timeout;
      count   <= timeout;
      pre     <= '0;
      armed   <= (timeout != '0);
    end else if (armed && kick_eff) begin
      count <= latched;
      pre   <= '0;
    end else if (expire) begin
      armed <= 1'b0;
      pre   <= '0;
      count <= '0;
    end else if (tick) begin
      pre   <= '0;
      count <= count - TMO_W'(1);
    end else if (armed) begin
      pre <= pre + PRE_W'(1);
    end
  end

endmodule

// File: rtl/wdt_cause_flags.sv
module wdt_cause_flags
  import wdt_cause_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               rtc_set,
  input  logic               expire,
  input  logic               ack_en,
  input  logic [CAUSE_W-1:0] ack_bits,
  output logic [CAUSE_W-1:0] cause
);

  logic [CAUSE_W-1:0] set_v, ack_v;
  assign set_v = expire ? {CAUSE_W{1'b1}} : {{(CAUSE_W-1){1'b0}}, rtc_set};
  assign ack_v = ack_en ? ack_bits : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause <= '0;
    else        cause <= cause_next(cause, set_v, ack_v);
  end

endmodule

// File: rtl/wdt_cause_top.sv
module wdt_cause_top
  import wdt_cause_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRESCALE = 1024
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              trigger,
  input  logic              kick,
  input  logic              rtc_restored,
  output logic              sys_rst_req
);

  logic [DATA_W-1:0]   timeout, count, latched;
  logic [PWR_KEEP-1:0] pwr_bits;
  logic                svc_pulse, kick_eff, armed, tick, expire, ack_en;
  logic [CAUSE_W-1:0]  cause;

  assign kick_eff = kick || svc_pulse;
  assign ack_en   = wr_en && (reg_sel_e'(wr_sel) == SEL_CAUSE);

  wdt_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .timeout(timeout), .pwr_bits(pwr_bits), .svc_pulse(svc_pulse)
  );

  wdt_down_counter #(.TMO_W(DATA_W), .PRESCALE(PRESCALE)) u_cnt (
    .clk(clk), .por_n(por_n), .trigger(trigger), .kick_eff(kick_eff),
    .timeout(timeout), .armed(armed), .tick(tick), .count(count),
    .latched(latched), .expire(expire)
  );

  wdt_cause_flags u_cause (
    .clk(clk), .por_n(por_n), .rtc_set(rtc_restored), .expire(expire),
    .ack_en(ack_en), .ack_bits(wr_data[CAUSE_W-1:0]), .cause(cause)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sys_rst_req <= 1'b0;
    else        sys_rst_req <= expire;
  end

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_TMO:   rd_data = timeout;
      SEL_CAUSE: rd_data = {{(DATA_W-CAUSE_W){1'b0}}, cause};
      SEL_PWR:   rd_data = {{(DATA_W-PWR_KEEP){1'b0}}, pwr_bits};
      default:   rd_data = {DATA_W{1'b1}};
    endcase
  end

endmodule

// File: rtl/wdt_cause_chk.sv
module wdt_cause_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              trigger,
  input logic              kick_eff,
  input logic              armed,
  input logic [DATA_W-1:0] timeout,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] latched,
  input logic              sys_rst_req,
  input logic [1:0]        cause,
  input logic              rtc_restored,
  input logic [1:0]        rd_sel,
  input logic [DATA_W-1:0] rd_data
);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |=> !sys_rst_req);

  p_expiry_cause_r6: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |-> (cause == 2'b11));

  p_zero_disarms_r3: assert property (@(posedge clk) disable iff (!por_n)
    (trigger && (timeout == '0)) |=> !armed);

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    !trigger |=> $stable(latched));

  p_kick_reload_r9: assert property (@(posedge clk) disable iff (!por_n)
    (armed && kick_eff && !trigger) |=> (count == latched));

  p_rtc_set_r7: assert property (@(posedge clk) disable iff (!por_n)
    rtc_restored |=> cause[0]);

  p_pwr_upper_r10: assert property (@(posedge clk) disable iff (!por_n)
    (rd_sel == 2'd2) |-> (rd_data[DATA_W-1:3] == '0));

endmodule

bind wdt_cause_top wdt_cause_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .por_n(por_n), .trigger(trigger), .kick_eff(kick_eff),
  .armed(armed), .timeout(timeout), .count(count), .latched(latched),
  .sys_rst_req(sys_rst_req), .cause(cause), .rtc_restored(rtc_restored),
  .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/test_wdt_cause_top.sv
module test_wdt_cause_top;
  import wdt_cause_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PRE        = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       trigger = 1'b0, kick = 1'b0, rtc_restored = 1'b0;
  logic       sys_rst_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_cause_top #(.DATA_W(8), .PRESCALE(PRE)) i_wdt_cause_top (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .trigger(trigger), .kick(kick),
    .rtc_restored(rtc_restored), .sys_rst_req(sys_rst_req)
  );

  // kind 0: compare rd_data, kind 1: compare sys_rst_req, kind 2: compare bench value
  typedef struct {
    int    kind;
    int    act_val;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    n_vec = 0, n_bad = 0;
  int    cyc = 0, rst_seen = 0, rst_cyc = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (sys_rst_req) begin rst_seen++; rst_cyc = cyc; end

  // Monitor: pops expected items and compares them away from the clock edge
  initial forever begin
    @(mon_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0:       act = int'(rd_data);
        1:       act = int'(sys_rst_req);
        default: act = it.act_val;
      endcase
      n_vec++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_rd(input logic [1:0] s, input int e, input string tag);
    item_t it;
    @(negedge clk);
    rd_sel = s;
    it.kind = 0; it.act_val = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic exp_val(input int a, input int e, input string tag);
    item_t it;
    it.kind = 2; it.act_val = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic exp_rst(input int e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = 1; it.act_val = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_trig(output int at);
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0; at = cyc;
  endtask

  task automatic pulse_kick(output int at);
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0; at = cyc;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, k0, w0, base;
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // R1 reset state
    exp_rd(2'd0, 0, "R1 timeout after reset");
    exp_rd(2'd1, 0, "R1 cause after reset");
    exp_rd(2'd2, 0, "R1 power after reset");
    exp_rst(0, "R1 reset request low");
    exp_rd(2'd3, 255, "R11 unmapped read");

    // R2 timeout byte, R11 unmapped write
    wr(2'd0, 8'hA5);
    exp_rd(2'd0, 8'hA5, "R2 timeout readback");
    wr(2'd3, 8'h12);
    exp_rd(2'd0, 8'hA5, "R11 write no-op timeout");
    exp_rd(2'd1, 0, "R11 write no-op cause");
    exp_rd(2'd2, 0, "R11 write no-op power");

    // R3 zero timeout disarms a running count and never expires
    base = rst_seen;
    wr(2'd0, 8'd5);
    pulse_trig(t0);
    wr(2'd0, 8'd0);
    pulse_trig(t0);
    repeat (300) @(negedge clk);
    exp_val(rst_seen - base, 0, "R3 zero trigger never expires");
    exp_rd(2'd1, 0, "R3 cause stays clear");

    // R4/R5 late write ignored, exact expiry distance, single pulse
    wr(2'd0, 8'd3);
    pulse_trig(t0);
    wr(2'd0, 8'd50);
    repeat (20) @(negedge clk);
    exp_val(rst_seen - base, 1, "R5 one expiry");
    exp_val(rst_cyc - t0, int'(expire_cycles(3, PRE)), "R4 late write ignored, R5 distance");
    exp_rd(2'd0, 50, "R4 register holds late value");
    exp_rd(2'd1, 3, "R6 expiry sets cause 3");
    repeat (250) @(negedge clk);
    exp_val(rst_seen - base, 1, "R5 disarmed after expiry");

    // R8 partial acknowledge, ignored upper bits, set beats clear
    wr(2'd1, 8'hFE);
    exp_rd(2'd1, 1, "R8 partial ack clears bit1 only");
    wr(2'd1, 8'h01);
    exp_rd(2'd1, 0, "R8 ack bit0");
    @(negedge clk);
    rtc_restored = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h01;
    @(negedge clk);
    rtc_restored = 1'b0; wr_en = 1'b0;
    exp_rd(2'd1, 1, "R8 set wins over clear");
    wr(2'd1, 8'hFC);
    exp_rd(2'd1, 1, "R8 upper write bits ignored");
    wr(2'd1, 8'h03);
    exp_rd(2'd1, 0, "R8 full ack");

    // R7 clock-restored flag
    @(negedge clk); rtc_restored = 1'b1;
    @(negedge clk); rtc_restored = 1'b0;
    exp_rd(2'd1, 1, "R7 rtc sets bit0");
    wr(2'd1, 8'h01);

    // R9 kick reloads the latched value, not the register
    base = rst_seen;
    wr(2'd0, 8'd2);
    pulse_trig(t0);
    repeat (4) @(negedge clk);
    wr(2'd0, 8'd40);
    pulse_kick(k0);
    repeat (40) @(negedge clk);
    exp_val(rst_seen - base, 1, "R9 one expiry after kick");
    exp_val(rst_cyc - k0, int'(expire_cycles(2, PRE)), "R9 kick reloads latched value");
    exp_rd(2'd1, 3, "R6 cause 3 after second expiry");
    pulse_kick(k0);
    repeat (60) @(negedge clk);
    exp_val(rst_seen - base, 1, "R9 kick ignored when disarmed");

    // R10 power-control mask and service pulse
    wr(2'd2, 8'hFF);
    exp_rd(2'd2, 7, "R10 power keeps bits 2:0");
    base = rst_seen;
    wr(2'd0, 8'd2);
    pulse_trig(t0);
    wr(2'd2, 8'h08);
    w0 = cyc;
    repeat (30) @(negedge clk);
    exp_val(rst_seen - base, 1, "R10 one expiry with service pulse");
    exp_val(rst_cyc - w0, int'(expire_cycles(2, PRE)) + 1, "R10 service pulse acts as kick");
    exp_rd(2'd2, 0, "R10 bit3 reads zero");

    // R6 only power-on reset clears the cause
    exp_rd(2'd1, 3, "R6 cause held");
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    exp_rd(2'd1, 0, "R6 por clears cause");
    exp_rst(0, "R1 request low after por");

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule